// File: doc/BRIEF.md
# Edge-Triggered Interrupt Inputs with Preset Event Counters

This block watches eight digital input pins and turns transitions on them into interrupt requests. Each pin first passes through a two-stage synchronizer. A registered copy of the synchronized level then serves as the previous sample, and an edge is a difference between the two. Every channel is configured on its own. The edge it reacts to may be rising or falling. In direct mode, every such edge produces a one-cycle request. In counter mode, edges step a 16-bit present value up or down, and a request goes out only when the programmed set value is reached; the count then reloads and keeps running.

Configuration uses a write strobe, a channel index and a field select. Select 0 writes the control bits of that channel, and select 1 writes its set value. The present value of any channel can be read at any time through a combinational read port. The requests leave as an eight-bit pulse vector. A priority encoder adds a summary flag and the vector number of the lowest requesting channel. The numbers 140 to 147 belong to channels 0 to 7.

Top module: `edge_event_irq`

## Requirements
- R1: After reset every channel is in direct mode, detects rising edges and counts up, with present value 0 and set value 0xFFFF. `irq_req` and `irq_any` are 0.
- R2: In direct mode with rising polarity, a low-to-high change on a pin sets that channel's `irq_req` bit three clock edges later, for exactly one cycle. A high-to-low change raises nothing.
- R3: The control word bit 1 selects the polarity: 0 means rising and 1 means falling. With falling selected, only high-to-low changes raise requests.
- R4: `irq_any` is the OR of `irq_req`. `irq_vector` equals 140 plus the index of the lowest set `irq_req` bit, and 0 when none is set.
- R5: When control bit 0 is 1 (counter mode) and control bit 2 is 0 (up), each qualifying edge adds one to the present value. The edge that would make it equal the set value raises a one-cycle request and leaves the present value at 0.
- R6: In counter mode with control bit 2 set to 1 (down), each qualifying edge subtracts one. The edge that would make it 0 raises a one-cycle request and reloads the set value.
- R7: A set-value write of 0 is ignored: the set value and the present value both stay as they were.
- R8: A control write reloads the present value, to 0 for up and to the set value for down. A nonzero set-value write stores the value and reloads the present value the same way. A write takes precedence over an edge in the same cycle.
- R9: Channels are independent: simultaneous edges on all eight pins are each counted and each raise their own request.
- R10: `rd_pv` shows the present value of the channel selected by `rd_ch`, combinationally.
- R11: In direct mode the present value does not change on edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 8 | Asynchronous input pins, one per channel |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 selects the control word (bit0 counter mode, bit1 falling, bit2 down), 1 selects the set value |
| wr_ch | input | 3 | Channel being written |
| wr_data | input | 16 | Write data |
| rd_ch | input | 3 | Channel whose present value is read |
| rd_pv | output | 16 | Present value of the selected channel |
| irq_req | output | 8 | One-cycle request pulses, one bit per channel |
| irq_any | output | 1 | Any request active |
| irq_vector | output | 8 | Vector number of the lowest requesting channel |

## Verification
A pin change made between clock edges reaches the first synchronizer flop at the next edge and the second flop at the edge after. The request and the updated present value register on the third edge. Every pin-stimulus task therefore waits three rising edges and samples on the following falling edge. Writes are presented for one cycle and take effect on the rising edge inside that cycle, so the present value is read back on the next falling edge. The one-cycle width of a request is confirmed one falling edge after it has been sampled high.

// File: rtl/edge_event_pkg.sv
package edge_event_pkg;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic [CNT_W-1:0] pv;
    logic             hit;
  } step_t;

  // value the present count takes after a write or after reaching the target
  function automatic logic [CNT_W-1:0] reload_val(input logic [CNT_W-1:0] sv,
                                                  input logic down);
    return down ? sv : '0;
  endfunction

  // one counting step; hit marks arrival at the target
  function automatic step_t count_step(input logic [CNT_W-1:0] pv,
                                       input logic [CNT_W-1:0] sv,
                                       input logic down);
    step_t r;
    logic [CNT_W-1:0] nx;
    nx = down ? pv - 1'b1 : pv + 1'b1;
    r.hit = down ? (nx == '0) : (nx == sv);
    r.pv  = r.hit ? reload_val(sv, down) : nx;
    return r;
  endfunction
endpackage

// File: rtl/eei_sync_edge.sv
module eei_sync_edge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_async,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] s1, s2, prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
    end else begin
      s1   <= pin_async;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign rise = s2 & ~prev;
  assign fall = ~s2 & prev;

  // R2
  rise_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |-> (rise & ~$past(s1)) == '0);
endmodule

// File: rtl/eei_channel.sv
module eei_channel
  import edge_event_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_rise,
  input  logic             edge_fall,
  input  logic             ctrl_we,
  input  logic [2:0]       ctrl_bits,
  input  logic             sv_we,
  input  logic [CNT_W-1:0] sv_data,
  output logic             irq,
  output logic [CNT_W-1:0] pv
);
  logic             mode_cnt, fall_sel, down;
  logic [CNT_W-1:0] sv;
  logic             hit_edge;
  step_t            step;

  assign hit_edge = fall_sel ? edge_fall : edge_rise;
  assign step     = count_step(pv, sv, down);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_cnt <= 1'b0;
      fall_sel <= 1'b0;
      down     <= 1'b0;
      sv       <= '1;
      pv       <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (ctrl_we) begin
        mode_cnt <= ctrl_bits[0];
        fall_sel <= ctrl_bits[1];
        down     <= ctrl_bits[2];
        pv       <= reload_val(sv, ctrl_bits[2]);
      end else if (sv_we) begin
        if (sv_data != '0) begin
          sv <= sv_data;
          pv <= reload_val(sv_data, down);
        end
      end else if (hit_edge) begin
        if (!mode_cnt) begin
          irq <= 1'b1;
        end else begin
          pv  <= step.pv;
          irq <= step.hit;
        end
      end
    end
  end

  // R2
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R2
  irq_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(edge_rise | edge_fall));
  // R5
  up_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cnt && !down) |-> pv < sv);
  // R6
  down_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cnt && down) |-> (pv != '0 && pv <= sv));
  // R7
  zero_sv_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sv_we && !ctrl_we && sv_data == '0) |=> ($stable(sv) && $stable(pv)));
  // R11
  direct_pv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_cnt && !ctrl_we && !sv_we) |=> $stable(pv));
endmodule

// File: rtl/edge_event_irq.sv
module edge_event_irq
  import edge_event_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int VW       = 8,
  parameter int VEC_BASE = 140
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          pin_in,
  input  logic                    wr_en,
  input  logic                    wr_sel,
  input  logic [$clog2(NCH)-1:0]  wr_ch,
  input  logic [CNT_W-1:0]        wr_data,
  input  logic [$clog2(NCH)-1:0]  rd_ch,
  output logic [CNT_W-1:0]        rd_pv,
  output logic [NCH-1:0]          irq_req,
  output logic                    irq_any,
  output logic [VW-1:0]           irq_vector
);
  localparam int CHW = $clog2(NCH);

  logic [NCH-1:0]   rise, fall;
  logic [CNT_W-1:0] pv_all [NCH];

  eei_sync_edge #(.N(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_in), .rise(rise), .fall(fall)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic ctrl_we_i, sv_we_i;
    assign ctrl_we_i = wr_en && !wr_sel && (wr_ch == CHW'(i));
    assign sv_we_i   = wr_en &&  wr_sel && (wr_ch == CHW'(i));
    eei_channel u_ch (
      .clk(clk), .rst_n(rst_n),
      .edge_rise(rise[i]), .edge_fall(fall[i]),
      .ctrl_we(ctrl_we_i), .ctrl_bits(wr_data[2:0]),
      .sv_we(sv_we_i), .sv_data(wr_data),
      .irq(irq_req[i]), .pv(pv_all[i])
    );
  end

  assign rd_pv   = pv_all[rd_ch];
  assign irq_any = |irq_req;

  always_comb begin
    irq_vector = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (irq_req[i]) irq_vector = VW'(VEC_BASE + i);
    end
  end

  // R4
  vector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> (irq_vector >= VW'(VEC_BASE) && irq_vector < VW'(VEC_BASE + NCH)));
  // R4
  vector_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[0] |-> irq_vector == VW'(VEC_BASE));
  // R4
  idle_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_any |-> irq_vector == '0);
endmodule

// File: tb/tb_edge_event_irq.sv
module tb_edge_event_irq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  pin_in;
  logic        wr_en, wr_sel;
  logic [2:0]  wr_ch, rd_ch;
  logic [15:0] wr_data, rd_pv;
  logic [7:0]  irq_req, irq_vector;
  logic        irq_any;

  logic [7:0] s_irq, s_vec;
  logic       s_any;
  logic [15:0] v;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  edge_event_irq dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_ch(wr_ch), .wr_data(wr_data), .rd_ch(rd_ch), .rd_pv(rd_pv),
    .irq_req(irq_req), .irq_any(irq_any), .irq_vector(irq_vector)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [2:0] ch, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_ch = ch; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive(input logic [7:0] val);
    pin_in = val;
    repeat (3) @(posedge clk);
    @(negedge clk);
    s_irq = irq_req; s_any = irq_any; s_vec = irq_vector;
  endtask

  task automatic rdpv(input logic [2:0] ch, output logic [15:0] o);
    rd_ch = ch; #1; o = rd_pv;
  endtask

  task automatic t_reset;
    chk("R1 irq_req", irq_req, 0);
    chk("R1 irq_any", irq_any, 0);
    for (int c = 0; c < 8; c++) begin
      rdpv(3'(c), v); chk("R1 pv", v, 0);
    end
  endtask

  task automatic t_direct;
    drive(8'h01);
    chk("R2 rise irq", s_irq, 8'h01);
    chk("R4 vector 140", s_vec, 140);
    chk("R4 any", s_any, 1);
    @(negedge clk);
    chk("R2 one cycle", irq_req, 0);
    drive(8'h00);
    chk("R2 fall ignored", s_irq, 0);
    rdpv(0, v); chk("R11 direct pv", v, 0);
  endtask

  task automatic t_falling;
    wr(0, 3, 16'h0002);
    drive(8'h08);
    chk("R3 rise ignored", s_irq, 0);
    drive(8'h00);
    chk("R3 fall irq", s_irq, 8'h08);
    chk("R4 vector 143", s_vec, 143);
    wr(0, 3, 16'h0000);
  endtask

  task automatic t_multi;
    drive(8'hFF);
    chk("R4 lowest wins", s_vec, 140);
    chk("R9 all direct", s_irq, 8'hFF);
    drive(8'h00);
    drive(8'hA0);
    chk("R4 vector 145", s_vec, 145);
    drive(8'h00);
    chk("R4 idle vector", irq_vector, 0);
  endtask

  task automatic t_count_up;
    wr(0, 2, 16'h0001);
    wr(1, 2, 16'd3);
    drive(8'h04); rdpv(2, v);
    chk("R5 pv 1", v, 1); chk("R5 no irq", s_irq[2], 0);
    drive(8'h00);
    drive(8'h04); rdpv(2, v);
    chk("R5 pv 2", v, 2);
    drive(8'h00);
    drive(8'h04); rdpv(2, v);
    chk("R5 hit irq", s_irq[2], 1);
    chk("R5 wrap pv", v, 0);
    drive(8'h00);
  endtask

  task automatic t_count_down;
    wr(0, 5, 16'h0005);
    rdpv(5, v); chk("R8 ctrl reload", v, 16'hFFFF);
    wr(1, 5, 16'd2);
    rdpv(5, v); chk("R8 sv reload", v, 2);
    drive(8'h20); rdpv(5, v);
    chk("R6 pv 1", v, 1); chk("R6 no irq", s_irq[5], 0);
    drive(8'h00);
    drive(8'h20); rdpv(5, v);
    chk("R6 hit irq", s_irq[5], 1);
    chk("R6 reload", v, 2);
    drive(8'h00);
  endtask

  task automatic t_zero_sv;
    wr(1, 5, 16'h0000);
    rdpv(5, v); chk("R7 pv kept", v, 2);
    drive(8'h20); rdpv(5, v); chk("R7 pv 1", v, 1);
    drive(8'h00);
    drive(8'h20); chk("R7 sv kept", s_irq[5], 1);
    drive(8'h00);
  endtask

  task automatic t_all_count;
    for (int c = 0; c < 8; c++) begin
      wr(0, 3'(c), 16'h0001);
      wr(1, 3'(c), 16'd2);
    end
    drive(8'hFF);
    chk("R9 no irq yet", s_irq, 0);
    for (int c = 0; c < 8; c++) begin
      rdpv(3'(c), v); chk("R10 R9 pv", v, 1);
    end
    drive(8'h00);
    drive(8'hFF);
    chk("R9 all fire", s_irq, 8'hFF);
    drive(8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_in = '0; wr_en = 0; wr_sel = 0; wr_ch = 0; wr_data = 0; rd_ch = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_falling();
    t_multi();
    t_count_up();
    t_count_down();
    t_zero_sv();
    t_all_count();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule